// File: doc/BRIEF.md
# Conversion Retry Pin Monitor

This block guards a multi-phase sensor conversion against disturbance from output pins that drive heavy loads. Each output source that might disturb the measurement, such as a serial bus driver or a port register write, presents a one-cycle switching strobe. Software enables monitoring for each source separately. When an enabled source switches while a conversion phase is running, that phase is marked as corrupted. The phase is then run again instead of being accepted. The rest of the conversion is not restarted.

The conversion is modelled as a counted sequencer. A start pulse begins a conversion. The sensing logic reports the end of each phase with a phase-done pulse, and the block then decides whether to repeat that phase, move to the next one, or finish. A retry cap, captured when the conversion starts, bounds the number of repeats so that every conversion completes. A sticky event flag records that at least one retry has happened. When the conversion finishes, a one-cycle completion pulse reports the number of retries it used.

The completion result is a plain pulse without back-pressure, because a conversion cannot be held once it has ended. All other pins are plain control and status signals.

Top module: `convretry_monitor`

## Requirements
- R1: After reset all per-source monitor enables read back as 0. A configuration write loads the enables and the limit mode, and both read back in the next cycle.
- R2: If an enabled source strobes during a running phase, that phase is repeated. `phase_idx` keeps its value for the repeat, and the retry count goes up by one.
- R3: A strobe from a source whose enable bit is 0 never causes a repeat and never changes the retry count.
- R4: The limit mode is encoded as follows: 00 means unlimited, 01 means at most 2 retries, 10 means at most 4 retries, and 11 means unlimited. The reset value is 00. The mode is captured when a conversion starts.
- R5: Once the cap is reached, further corruption is ignored. The conversion then accepts each phase and finishes after NUM_PHASES accepted phases.
- R6: The event flag is 0 after reset. It is set by every retry and stays set until a write of 1 to `flag_clr` or a reset.
- R7: The retry count is 0 in the cycle after a conversion starts.
- R8: A strobe in the same cycle as `phase_done` counts as corrupting that phase.
- R9: If `flag_clr` and a retry occur in the same cycle, the flag ends up set.
- R10: `done_pulse` is high for exactly one cycle, two cycles after the `phase_done` of the last accepted phase. In that cycle `done_retries` gives the retry count, which saturates at its all-ones value when retries are unlimited.
- R11: A start pulse is accepted only when the block is idle. Within a conversion, `phase_idx` either holds its value or advances by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Strobe that writes the enables and the limit mode |
| cfg_en_wdata | input | NUM_SRC | New per-source enables |
| cfg_mode_wdata | input | 2 | New limit mode |
| flag_clr | input | 1 | Write-1 clear of the event flag |
| cfg_en_q | output | NUM_SRC | Current enables |
| cfg_mode_q | output | 2 | Current limit mode |
| event_flag | output | 1 | Sticky flag that records a retry |
| src_evt | input | NUM_SRC | Per-source switching strobes |
| conv_start | input | 1 | Conversion start pulse |
| phase_done | input | 1 | End-of-phase pulse from the sensing logic |
| conv_busy | output | 1 | High while a conversion is in progress |
| phase_run | output | 1 | High while a phase is running |
| phase_idx | output | IDX_W | Index of the current phase |
| retry_cnt | output | CNT_W | Retries used in this conversion |
| done_pulse | output | 1 | One-cycle completion pulse |
| done_retries | output | CNT_W | Retry count, valid with `done_pulse` |

## Verification
The bench builds the block with three sources, three phases and a 4-bit retry counter. The short phase count keeps every conversion brief. The narrow counter means that saturation at 15 is reached by a single conversion with seventeen corrupted attempts. With three sources, one enabled source and two disabled ones can be driven at the same time, which checks the per-source masking. All four mode codes are exercised, along with same-cycle strobe and phase-done, and a flag clear that coincides with a retry.

// File: rtl/crm_pkg.sv
package crm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_CHECK = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;

  localparam logic [1:0] LIM_NONE = 2'b00;
  localparam logic [1:0] LIM_TWO  = 2'b01;
  localparam logic [1:0] LIM_FOUR = 2'b10;

  localparam int unsigned CAP_TWO  = 2;
  localparam int unsigned CAP_FOUR = 4;
endpackage

// File: rtl/crm_cfg_regs.sv
module crm_cfg_regs #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [NUM_SRC-1:0] cfg_en_wdata,
  input  logic [1:0]         cfg_mode_wdata,
  input  logic               flag_clr,
  input  logic               retry_fire,
  output logic [NUM_SRC-1:0] en_q,
  output logic [1:0]         mode_q,
  output logic               flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= crm_pkg::LIM_NONE;
    end else if (cfg_wr) begin
      en_q   <= cfg_en_wdata;
      mode_q <= cfg_mode_wdata;
    end
  end

  // A retry sets the flag, and setting wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (retry_fire) flag_q <= 1'b1;
    else if (flag_clr)   flag_q <= 1'b0;
  end
endmodule

// File: rtl/crm_corrupt_detect.sv
module crm_corrupt_detect #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic [NUM_SRC-1:0] en,
  input  logic               watch,
  input  logic               consume,
  output logic               corrupt_q
);
  logic [NUM_SRC-1:0] masked;
  logic               hit;

  // Only strobes from enabled sources are kept; the rest are masked out.
  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_mask
      assign masked[g] = src_evt[g] & en[g];
    end
  endgenerate

  assign hit = |masked;

  // The mark collects hits over a whole phase, including the phase-done cycle.
  // It is cleared when the sequencer reads it in the check cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       corrupt_q <= 1'b0;
    else if (consume) corrupt_q <= 1'b0;
    else if (watch)   corrupt_q <= corrupt_q | hit;
  end
endmodule

// File: rtl/crm_sequencer.sv
module crm_sequencer
  import crm_pkg::*;
#(
  parameter int NUM_PHASES = 8,
  parameter int CNT_W      = 6,
  localparam int IDX_W     = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic             phase_done,
  input  logic             corrupt,
  input  logic [1:0]       mode,
  output seq_state_t       state,
  output logic [IDX_W-1:0] phase_idx,
  output logic [CNT_W-1:0] retry_cnt,
  output logic             retry_fire
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PHASES - 1);
  localparam logic [CNT_W-1:0] CAP2     = CNT_W'(CAP_TWO);
  localparam logic [CNT_W-1:0] CAP4     = CNT_W'(CAP_FOUR);

  logic [1:0] lim_q;
  logic       capped;
  logic       start_ok;

  assign start_ok = (state == ST_IDLE) && conv_start;

  // The cap follows the limit mode captured at start.
  always_comb begin
    case (lim_q)
      LIM_TWO:  capped = (retry_cnt >= CAP2);
      LIM_FOUR: capped = (retry_cnt >= CAP4);
      default:  capped = 1'b0;
    endcase
  end

  assign retry_fire = (state == ST_CHECK) && corrupt && !capped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phase_idx <= '0;
      retry_cnt <= '0;
      lim_q     <= LIM_NONE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_ok) begin
            state     <= ST_RUN;
            phase_idx <= '0;
            retry_cnt <= '0;
            lim_q     <= mode;
          end
        end
        ST_RUN: begin
          if (phase_done) state <= ST_CHECK;
        end
        ST_CHECK: begin
          if (retry_fire) begin
            state <= ST_RUN;
            // The count saturates when retries are unlimited.
            if (retry_cnt != '1) retry_cnt <= retry_cnt + 1'b1;
          end else if (phase_idx == LAST_IDX) begin
            state <= ST_DONE;
          end else begin
            state     <= ST_RUN;
            phase_idx <= phase_idx + 1'b1;
          end
        end
        default: begin
          state     <= ST_IDLE;
          phase_idx <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/convretry_monitor.sv
module convretry_monitor
  import crm_pkg::*;
#(
  parameter int NUM_SRC    = 4,
  parameter int NUM_PHASES = 8,
  parameter int CNT_W      = 6,
  localparam int IDX_W     = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [NUM_SRC-1:0] cfg_en_wdata,
  input  logic [1:0]         cfg_mode_wdata,
  input  logic               flag_clr,
  output logic [NUM_SRC-1:0] cfg_en_q,
  output logic [1:0]         cfg_mode_q,
  output logic               event_flag,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic               conv_start,
  input  logic               phase_done,
  output logic               conv_busy,
  output logic               phase_run,
  output logic [IDX_W-1:0]   phase_idx,
  output logic [CNT_W-1:0]   retry_cnt,
  output logic               done_pulse,
  output logic [CNT_W-1:0]   done_retries
);
  seq_state_t state;
  logic       corrupt;
  logic       retry_fire;

  crm_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr         (cfg_wr),
    .cfg_en_wdata   (cfg_en_wdata),
    .cfg_mode_wdata (cfg_mode_wdata),
    .flag_clr       (flag_clr),
    .retry_fire     (retry_fire),
    .en_q           (cfg_en_q),
    .mode_q         (cfg_mode_q),
    .flag_q         (event_flag)
  );

  crm_corrupt_detect #(.NUM_SRC(NUM_SRC)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_evt   (src_evt),
    .en        (cfg_en_q),
    .watch     (state == ST_RUN),
    .consume   (state == ST_CHECK),
    .corrupt_q (corrupt)
  );

  crm_sequencer #(.NUM_PHASES(NUM_PHASES), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .phase_done (phase_done),
    .corrupt    (corrupt),
    .mode       (cfg_mode_q),
    .state      (state),
    .phase_idx  (phase_idx),
    .retry_cnt  (retry_cnt),
    .retry_fire (retry_fire)
  );

  assign conv_busy    = (state != ST_IDLE);
  assign phase_run    = (state == ST_RUN);
  assign done_pulse   = (state == ST_DONE);
  assign done_retries = done_pulse ? retry_cnt : '0;
endmodule

// File: rtl/crm_checker.sv
module crm_checker #(
  parameter int NUM_SRC    = 4,
  parameter int NUM_PHASES = 8,
  parameter int CNT_W      = 6,
  localparam int IDX_W     = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr,
  input logic [NUM_SRC-1:0] cfg_en_wdata,
  input logic [NUM_SRC-1:0] cfg_en_q,
  input logic               flag_clr,
  input logic               event_flag,
  input logic               conv_start,
  input logic               conv_busy,
  input logic [IDX_W-1:0]   phase_idx,
  input logic [CNT_W-1:0]   retry_cnt,
  input logic               done_pulse
);
  // R1
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_en_q == $past(cfg_en_wdata));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (event_flag && !flag_clr) |=> event_flag);

  // R7
  count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !conv_busy) |=> retry_cnt == '0);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  // R11
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && $past(conv_busy) && !done_pulse) |->
      (phase_idx == $past(phase_idx) || phase_idx == $past(phase_idx) + 1'b1));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && $past(conv_busy)) |->
      (retry_cnt == $past(retry_cnt) || retry_cnt == $past(retry_cnt) + 1'b1));
endmodule

bind convretry_monitor crm_checker #(
  .NUM_SRC(NUM_SRC), .NUM_PHASES(NUM_PHASES), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr       (cfg_wr),
  .cfg_en_wdata (cfg_en_wdata),
  .cfg_en_q     (cfg_en_q),
  .flag_clr     (flag_clr),
  .event_flag   (event_flag),
  .conv_start   (conv_start),
  .conv_busy    (conv_busy),
  .phase_idx    (phase_idx),
  .retry_cnt    (retry_cnt),
  .done_pulse   (done_pulse)
);

// File: tb/sim_convretry_monitor.sv
`timescale 1ns/1ps
module sim_convretry_monitor;
  localparam int NS  = 3;
  localparam int NPH = 3;
  localparam int CW  = 4;
  localparam int IW  = $clog2(NPH);
  localparam int SAT = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [NS-1:0] cfg_en_wdata = '0;
  logic [1:0]    cfg_mode_wdata = '0;
  logic          flag_clr = 1'b0;
  logic [NS-1:0] cfg_en_q;
  logic [1:0]    cfg_mode_q;
  logic          event_flag;
  logic [NS-1:0] src_evt = '0;
  logic          conv_start = 1'b0;
  logic          phase_done = 1'b0;
  logic          conv_busy, phase_run, done_pulse;
  logic [IW-1:0] phase_idx;
  logic [CW-1:0] retry_cnt, done_retries;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  int exp_q[$];
  logic [NS-1:0] cur_en = '0;
  logic [1:0]    cur_mode = '0;

  always #2 clk = ~clk;

  convretry_monitor #(.NUM_SRC(NS), .NUM_PHASES(NPH), .CNT_W(CW)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Monitor: pops one expected count per completion pulse (R10).
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (done_pulse) begin
        if (exp_q.size() == 0) chk(0, "R10 unexpected done", 1, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(done_retries) == e, "R10 done_retries", int'(done_retries), e);
        end
      end
    end
  end

  task automatic wr_cfg(input logic [NS-1:0] en, input logic [1:0] mode);
    @(negedge clk);
    cfg_wr = 1; cfg_en_wdata = en; cfg_mode_wdata = mode;
    @(negedge clk);
    cfg_wr = 0;
    cur_en = en; cur_mode = mode;
    chk(cfg_en_q == en, "R1 enable readback", int'(cfg_en_q), int'(en));
    chk(cfg_mode_q == mode, "R4 mode readback", int'(cfg_mode_q), int'(mode));
  endtask

  // Driver: runs one conversion and pushes the expected retry count.
  task automatic run_conv(input logic [NS-1:0] pat, input int n_corrupt,
                          input bit same_cyc, input bit clr_on_retry);
    int lim, exp_r, budget, ph;
    lim = (cur_mode == 2'b01) ? 2 : (cur_mode == 2'b10) ? 4 : 0;
    exp_r = 0; budget = n_corrupt; ph = 0;
    @(negedge clk);
    conv_start = 1;
    @(negedge clk);
    conv_start = 0;
    chk(retry_cnt == '0, "R7 count cleared at start", int'(retry_cnt), 0);
    while (ph < NPH) begin
      bit inj, hit;
      inj = (budget > 0);
      if (inj) budget--;
      if (inj && !same_cyc) src_evt = pat;
      @(negedge clk);
      src_evt = '0;
      phase_done = 1;
      if (inj && same_cyc) src_evt = pat;
      @(negedge clk);
      phase_done = 0; src_evt = '0;
      hit = inj && ((pat & cur_en) != '0);
      if (hit && !(lim > 0 && exp_r >= lim)) begin
        if (exp_r < SAT) exp_r++;
        if (clr_on_retry) flag_clr = 1;
      end else ph++;
      if (ph == NPH) exp_q.push_back(exp_r);
      @(negedge clk);
      flag_clr = 0;
      if (ph < NPH)
        chk(phase_idx == IW'(ph), "R2/R5 phase index", int'(phase_idx), ph);
    end
    @(negedge clk);
    @(negedge clk);
    chk(int'(retry_cnt) == exp_r, "R5 final retry count", int'(retry_cnt), exp_r);
    chk(!conv_busy, "R10 back to idle", int'(conv_busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cfg_en_q == '0, "R1 reset enables", int'(cfg_en_q), 0);
    chk(cfg_mode_q == 2'b00, "R4 reset mode", int'(cfg_mode_q), 0);
    chk(!event_flag, "R6 reset flag", int'(event_flag), 0);
    chk(!conv_busy && !done_pulse, "R11 reset idle", int'(conv_busy), 0);

    // R3: all sources disabled, strobes have no effect
    run_conv(3'b111, 3, 0, 0);
    chk(!event_flag, "R3 flag untouched", int'(event_flag), 0);

    // R3: only bit 0 enabled, strobes on bits 1 and 2
    wr_cfg(3'b001, 2'b00);
    run_conv(3'b110, 3, 0, 0);
    chk(!event_flag, "R3 masked sources", int'(event_flag), 0);

    // R2 R4: unlimited mode 00, five retries
    run_conv(3'b011, 5, 0, 0);
    chk(event_flag, "R6 flag set by retry", int'(event_flag), 1);

    // R6: sticky across a clean conversion
    run_conv(3'b001, 0, 0, 0);
    chk(event_flag, "R6 flag sticky", int'(event_flag), 1);
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    chk(!event_flag, "R6 flag cleared", int'(event_flag), 0);

    // R4 R5: cap of two
    wr_cfg(3'b101, 2'b01);
    run_conv(3'b100, 5, 0, 0);
    // R4 R5: cap of four
    wr_cfg(3'b101, 2'b10);
    run_conv(3'b001, 6, 0, 0);
    // R4: code 11 unlimited
    wr_cfg(3'b101, 2'b11);
    run_conv(3'b001, 5, 0, 0);

    // R8: strobe in the same cycle as phase_done
    wr_cfg(3'b010, 2'b00);
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    run_conv(3'b010, 2, 1, 0);
    chk(event_flag, "R8 same-cycle strobe counted", int'(event_flag), 1);

    // R9: clear coincides with a retry
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    run_conv(3'b010, 1, 0, 1);
    chk(event_flag, "R9 set wins over clear", int'(event_flag), 1);

    // R10: saturation of the count when unlimited
    run_conv(3'b010, SAT + 2, 0, 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all completions seen", exp_q.size(), 0);
    finish_run();
  end
endmodule